// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block sits next to an instruction fetch unit and provides zero-overhead loops. When a loop-setup instruction completes, the block records a new level on a small loop stack. Each level holds the body start address, the address of the body's last instruction and the number of iterations still to run. The iteration count comes from one of two sources: a general-register value, or a narrow immediate that is zero-extended. The body length is always given as a number of instructions.

For every other completed instruction, the block compares the instruction address with the end address of the innermost loop only. On a match with iterations remaining, it overrides the next fetch address with the body start and counts the iteration down. On a match in the final iteration, it pops that level and lets fetch fall through.

Branches and jumps inside a body are allowed. A level leaves the stack only through its own final end instruction, one level per instruction. Misuse is not detected: two nested loops that share an end address, or an outer end reached before the inner loop is done, raise no error. The only error flag covers a setup that cannot be pushed: stack full, zero iterations, or an empty body.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset the stack is empty, and no completed instruction causes a redirect, at any address.
- R2: A setup with `cnt_from_reg`=1 takes its iteration count from `reg_count`. The immediate is ignored.
- R3: A setup with `cnt_from_reg`=0 takes its iteration count from `imm_count`, zero-extended. The register value is ignored.
- R4: A setup completed at address P with body length L gives a body start of P+1 and an end address of P+L (modulo 2^PC_W). A redirect always targets P+1.
- R5: A loop of N iterations redirects on the first N-1 completions of its end instruction. On the N-th completion it does not redirect, and it pops its level.
- R6: Loops nest. Once an inner level is popped, the enclosing level is compared again and keeps its remaining count.
- R7: Only the innermost level is compared. Reaching an outer end address while an inner loop is active causes neither a redirect nor an error, and leaves the outer count unchanged.
- R8: At most one level is popped per completed instruction, even when nested levels share an end address.
- R9: A setup arriving while 8 levels are stacked raises `loop_err` in that cycle and pushes nothing.
- R10: A setup whose selected iteration count is zero raises `loop_err` and pushes nothing.
- R11: A setup with a body length of zero raises `loop_err` and pushes nothing.
- R12: Inputs are ignored while `instr_valid` is 0. There is no redirect, no error, and no change to the stack.
- R13: A completed setup instruction is never itself compared against the end address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction completes this cycle |
| instr_pc | input | PC_W (16) | Address of the completing instruction |
| is_loop | input | 1 | The completing instruction is a loop setup |
| cnt_from_reg | input | 1 | 1: count from register, 0: count from immediate |
| reg_count | input | CNT_W (8) | Register-sourced iteration count |
| imm_count | input | IMM_W (6) | Immediate iteration count, zero-extended |
| body_len | input | LEN_W (8) | Loop body length in instructions |
| redirect_valid | output | 1 | Next fetch address is overridden this cycle |
| redirect_pc | output | PC_W (16) | Overriding fetch address (body start) |
| loop_err | output | 1 | Setup rejected this cycle |

## Verification
`redirect_valid`, `redirect_pc` and `loop_err` are combinational, so each is due in the same cycle as the completing instruction that causes it. The stack changes at the following rising edge and first shows its effect on the next instruction. The bench drives each instruction at the falling edge and compares the outputs 2 ns later, before the rising edge. It advances its own stack model only after that edge. Consequently, every check of a push, count-down or pop is made on the instruction that follows it. The same applies to the ignored cases: after a rejected or invalid input, the next loop-end instruction shows that the stack did not move.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  // Address of the last body instruction for a setup at pc with len instructions
  function automatic logic [31:0] body_end_addr(input logic [31:0] pc, input logic [31:0] len);
    return pc + len;
  endfunction

  // First body instruction sits right after the setup instruction
  function automatic logic [31:0] body_first_addr(input logic [31:0] pc);
    return pc + 32'd1;
  endfunction

  // A level keeps looping while more than one pass remains
  function automatic logic more_passes(input logic [31:0] remaining);
    return remaining > 32'd1;
  endfunction

endpackage

// File: rtl/hwloop_start_dec.sv
module hwloop_start_dec #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 8,
  parameter int IMM_W = 6,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             cnt_from_reg,
  input  logic [CNT_W-1:0] reg_count,
  input  logic [IMM_W-1:0] imm_count,
  input  logic [LEN_W-1:0] body_len,
  input  logic [PC_W-1:0]  setup_pc,
  input  logic             stack_full,
  output logic             push_en,
  output logic             reject,
  output logic [PC_W-1:0]  push_first,
  output logic [PC_W-1:0]  push_last,
  output logic [CNT_W-1:0] push_cnt
);
  import hwloop_pkg::*;

  logic sel_zero_cnt, zero_len;

  always_comb begin
    push_cnt   = cnt_from_reg ? reg_count : CNT_W'(imm_count);
    push_first = PC_W'(body_first_addr(32'(setup_pc)));
    push_last  = PC_W'(body_end_addr(32'(setup_pc), 32'(body_len)));
  end

  assign sel_zero_cnt = (push_cnt == '0);
  assign zero_len     = (body_len == '0);
  assign reject       = start_req && (stack_full || sel_zero_cnt || zero_len);
  assign push_en      = start_req && !reject;

  // R10
  nonzero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (cnt_from_reg ? reg_count != '0 : imm_count != '0));

  // R11
  nonempty_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> push_last != setup_pc);

endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [PC_W-1:0]  push_first,
  input  logic [PC_W-1:0]  push_last,
  input  logic [CNT_W-1:0] push_cnt,
  input  logic             pop_en,
  input  logic             dec_en,
  output logic             top_valid,
  output logic             full,
  output logic [PC_W-1:0]  top_first,
  output logic [PC_W-1:0]  top_last,
  output logic [CNT_W-1:0] top_cnt
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PC_W-1:0]  first_q [DEPTH];
  logic [PC_W-1:0]  last_q  [DEPTH];
  logic [CNT_W-1:0] cnt_q   [DEPTH];
  logic [SP_W-1:0]  sp_q;
  logic [IDX_W-1:0] top_idx, push_idx;

  assign top_idx   = IDX_W'(sp_q - SP_W'(1));
  assign push_idx  = IDX_W'(sp_q);
  assign top_valid = (sp_q != '0);
  assign full      = (sp_q == SP_W'(DEPTH));
  assign top_first = first_q[top_idx];
  assign top_last  = last_q[top_idx];
  assign top_cnt   = cnt_q[top_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        first_q[g] <= '0;
        last_q[g]  <= '0;
        cnt_q[g]   <= '0;
      end else if (push_en && push_idx == IDX_W'(g)) begin
        first_q[g] <= push_first;
        last_q[g]  <= push_last;
        cnt_q[g]   <= push_cnt;
      end else if (dec_en && top_idx == IDX_W'(g)) begin
        cnt_q[g] <= cnt_q[g] - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= '0;
    else if (push_en) sp_q <= sp_q + SP_W'(1);
    else if (pop_en)  sp_q <= sp_q - SP_W'(1);
  end

  // R9
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);

  // R13
  no_push_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !(pop_en || dec_en));

  // R8
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> (sp_q + SP_W'(1) == $past(sp_q)));

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> (top_cnt == $past(top_cnt) - CNT_W'(1)) && $stable(top_last));

endmodule

// File: rtl/hwloop_end_match.sv
module hwloop_end_match #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             plain_done,
  input  logic [PC_W-1:0]  pc,
  input  logic             top_valid,
  input  logic [PC_W-1:0]  top_first,
  input  logic [PC_W-1:0]  top_last,
  input  logic [CNT_W-1:0] top_cnt,
  output logic             iter_en,
  output logic             pop_en,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc
);
  import hwloop_pkg::*;

  logic at_end, again;

  assign at_end = plain_done && top_valid && (pc == top_last);
  assign again  = more_passes(32'(top_cnt));

  assign iter_en        = at_end && again;
  assign pop_en         = at_end && !again;
  assign redirect_valid = iter_en;
  assign redirect_pc    = top_first;

  // R1
  redirect_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> top_valid);

  // R5
  pop_on_last_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> top_cnt == CNT_W'(1));

  // R7
  only_top_compared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en || iter_en) |-> pc == top_last);

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 8,
  parameter int IMM_W = 6,
  parameter int LEN_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [PC_W-1:0]  instr_pc,
  input  logic             is_loop,
  input  logic             cnt_from_reg,
  input  logic [CNT_W-1:0] reg_count,
  input  logic [IMM_W-1:0] imm_count,
  input  logic [LEN_W-1:0] body_len,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             loop_err
);
  logic             start_req, plain_done;
  logic             push_en, pop_en, dec_en, full, top_valid;
  logic [PC_W-1:0]  push_first, push_last, top_first, top_last;
  logic [CNT_W-1:0] push_cnt, top_cnt;

  assign start_req  = instr_valid && is_loop;
  assign plain_done = instr_valid && !is_loop;

  hwloop_start_dec #(.PC_W(PC_W), .CNT_W(CNT_W), .IMM_W(IMM_W), .LEN_W(LEN_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cnt_from_reg(cnt_from_reg),
    .reg_count(reg_count), .imm_count(imm_count), .body_len(body_len),
    .setup_pc(instr_pc), .stack_full(full), .push_en(push_en), .reject(loop_err),
    .push_first(push_first), .push_last(push_last), .push_cnt(push_cnt)
  );

  hwloop_stack #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_first(push_first),
    .push_last(push_last), .push_cnt(push_cnt), .pop_en(pop_en), .dec_en(dec_en),
    .top_valid(top_valid), .full(full), .top_first(top_first),
    .top_last(top_last), .top_cnt(top_cnt)
  );

  hwloop_end_match #(.PC_W(PC_W), .CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .plain_done(plain_done), .pc(instr_pc),
    .top_valid(top_valid), .top_first(top_first), .top_last(top_last),
    .top_cnt(top_cnt), .iter_en(dec_en), .pop_en(pop_en),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !redirect_valid && !loop_err);

endmodule

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_pc = '0;
  logic        is_loop = 1'b0;
  logic        cnt_from_reg = 1'b0;
  logic [7:0]  reg_count = '0;
  logic [5:0]  imm_count = '0;
  logic [7:0]  body_len = '0;
  logic        redirect_valid;
  logic [15:0] redirect_pc;
  logic        loop_err;

  int compared = 0;
  int mismatched = 0;

  // bench stack model
  logic [15:0] m_first [DEPTH];
  logic [15:0] m_last  [DEPTH];
  int          m_cnt   [DEPTH];
  int          m_sp = 0;

  always #5 clk = ~clk;

  hwloop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_pc(instr_pc),
    .is_loop(is_loop), .cnt_from_reg(cnt_from_reg), .reg_count(reg_count),
    .imm_count(imm_count), .body_len(body_len), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .loop_err(loop_err)
  );

  function automatic int sel_count(logic ur, logic [7:0] rc, logic [5:0] ic);
    return ur ? int'(rc) : int'(ic);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [15:0] pc, logic lp,
                      logic ur, logic [7:0] rc, logic [5:0] ic, logic [7:0] len);
    int  cnt;
    logic e_err, e_rv, e_pop, e_push;
    cnt    = sel_count(ur, rc, ic);
    e_err  = v && lp && (m_sp == DEPTH || cnt == 0 || len == 0);
    e_push = v && lp && !e_err;
    e_rv   = 1'b0;
    e_pop  = 1'b0;
    if (v && !lp && m_sp > 0 && pc == m_last[m_sp-1]) begin
      e_rv  = m_cnt[m_sp-1] > 1;
      e_pop = !e_rv;
    end
    @(negedge clk);
    instr_valid = v; instr_pc = pc; is_loop = lp; cnt_from_reg = ur;
    reg_count = rc; imm_count = ic; body_len = len;
    #2;
    check({tag, " redirect_valid"}, 32'(redirect_valid), 32'(e_rv));
    check({tag, " loop_err"}, 32'(loop_err), 32'(e_err));
    if (e_rv) check({tag, " redirect_pc"}, 32'(redirect_pc), 32'(m_first[m_sp-1]));
    @(posedge clk);
    if (e_push) begin
      m_first[m_sp] = pc + 16'd1;
      m_last[m_sp]  = pc + 16'(len);
      m_cnt[m_sp]   = cnt;
      m_sp++;
    end else if (e_rv) begin
      m_cnt[m_sp-1]--;
    end else if (e_pop) begin
      m_sp--;
    end
  endtask

  task automatic run(string tag, logic [15:0] pc);
    step(tag, 1'b1, pc, 1'b0, 1'b0, 8'd0, 6'd0, 8'd0);
  endtask

  task automatic imm_loop(string tag, logic [15:0] pc, logic [5:0] n, logic [7:0] len);
    step(tag, 1'b1, pc, 1'b1, 1'b0, 8'hA5, n, len);
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 2000 && m_sp > 0; k++) run(tag, m_last[m_sp-1]);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty stack never redirects
    run("R1", 16'd0);
    run("R1", 16'd12);

    // R3, R4, R5: immediate count 3, setup at 10, body 11..12
    imm_loop("R3", 16'd10, 6'd3, 8'd2);
    run("R4", 16'd11);
    run("R4", 16'd12);
    run("R5", 16'd11);
    run("R5", 16'd12);
    run("R5", 16'd11);
    run("R5", 16'd12);   // final pass: pop, no redirect
    run("R5", 16'd12);   // popped: falls through

    // R2: register count 2, immediate value must be ignored
    step("R2", 1'b1, 16'd100, 1'b1, 1'b1, 8'd2, 6'd7, 8'd1);
    run("R2", 16'd101);
    run("R2", 16'd101);
    run("R2", 16'd101);

    // R6: outer 20 (2x, end 25), inner 21 (2x, end 23)
    imm_loop("R6", 16'd20, 6'd2, 8'd5);
    for (int p = 0; p < 2; p++) begin
      imm_loop("R6", 16'd21, 6'd2, 8'd2);
      run("R6", 16'd23); run("R6", 16'd23);
      run("R6", 16'd25);
    end
    run("R6", 16'd25);

    // R7: outer end reached while inner active
    imm_loop("R7", 16'd30, 6'd2, 8'd6);
    imm_loop("R7", 16'd31, 6'd3, 8'd2);
    run("R7", 16'd36);
    run("R7", 16'd33); run("R7", 16'd33); run("R7", 16'd33);
    run("R7", 16'd36); run("R7", 16'd36);

    // R8: shared end address pops one level per instruction
    imm_loop("R8", 16'd40, 6'd2, 8'd3);
    imm_loop("R8", 16'd41, 6'd2, 8'd2);
    run("R8", 16'd43); run("R8", 16'd43); run("R8", 16'd43);
    drain("R8");

    // R9: ninth setup rejected
    for (int i = 0; i < DEPTH; i++) imm_loop("R9", 16'(200 + i), 6'd2, 8'(40 - i));
    imm_loop("R9", 16'd300, 6'd2, 8'd1);
    run("R9", 16'd301);   // would match the rejected loop's end
    drain("R9");

    // R10 / R11: zero count and empty body rejected
    imm_loop("R10", 16'd50, 6'd0, 8'd1);
    step("R10", 1'b1, 16'd60, 1'b1, 1'b1, 8'd0, 6'd5, 8'd1);
    run("R10", 16'd51);
    imm_loop("R11", 16'd70, 6'd3, 8'd0);
    run("R11", 16'd70);

    // R12: invalid cycles ignored; R13: setup at end address not compared
    imm_loop("R12", 16'd80, 6'd2, 8'd2);
    step("R12", 1'b0, 16'd82, 1'b0, 1'b0, 8'd0, 6'd0, 8'd0);
    step("R12", 1'b0, 16'd90, 1'b1, 1'b0, 8'd0, 6'd3, 8'd1);
    step("R13", 1'b1, 16'd82, 1'b1, 1'b0, 8'd0, 6'd1, 8'd1);
    run("R13", 16'd83);
    drain("R12");

    // constrained random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(99, 0));
      if (r < 18)
        step("R5 rnd", 1'b1, 16'($urandom_range(4000, 0)), 1'b1, 1'($urandom),
             8'($urandom_range(4, 0)), 6'($urandom_range(4, 0)), 8'($urandom_range(6, 0)));
      else if (r < 75 && m_sp > 0)
        run("R6 rnd", m_last[m_sp-1]);
      else if (r < 85 && m_sp > 1)
        run("R7 rnd", m_last[m_sp-2]);
      else
        step("R12 rnd", 1'($urandom), 16'($urandom_range(4000, 0)), 1'b0,
             1'b0, 8'd0, 6'd0, 8'd0);
    end
    drain("R8 rnd");
    run("R1 end", 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule